// File: doc/BRIEF.md
# Bursty BER signal-degrade detector

The block watches a stream of per-frame errored-bit counts, for example parity violation counts taken from a line overhead. It adds them up over one-second intervals. An external tick pulse, one cycle wide, ends each interval. When an interval closes, its total is compared with two separate 20-bit thresholds:

- A total at or above the detection threshold marks the interval as bad.
- A total at or below the recovery threshold marks it as good.

A configurable run of consecutive bad intervals declares the degrade defect. A separate run of consecutive good intervals clears it. The gap between the two thresholds, together with the two run lengths, gives the defect hysteresis.

Each threshold arrives as a 16-bit low part and a 4-bit high part. The surrounding logic supplies them, along with the two run lengths, the tick and the counts. The block outputs the defect level and a one-cycle pulse on every change of that level.

Top module: `deg_detector`

## Requirements
- R1: The errored-bit counts presented with `err_valid_i` are summed over each interval. A count presented in the same cycle as `tick_i` belongs to the interval that is ending. The sum restarts at zero for the next interval.
- R2: An interval is bad when its total is greater than or equal to `{det_thr_hi_i, det_thr_lo_i}`. The high part forms bits 19..16 and the low part forms bits 15..0.
- R3: An interval is good when its total is less than or equal to `{rec_thr_hi_i, rec_thr_lo_i}`, with the same bit layout as R2.
- R4: While `deg_o` is 0, `det_win_i` consecutive bad intervals set `deg_o`, and any interval that is not bad restarts the run. `deg_o` changes only at the clock edge where `tick_i` is sampled high.
- R5: While `deg_o` is 1, `rec_win_i` consecutive good intervals clear `deg_o`, and any interval that is not good restarts the run.
- R6: A run length below 2 is treated as 2, and a run length above 10 is treated as 10.
- R7: The interval sum saturates at 2^ACC_W-1 instead of wrapping.
- R8: After reset, `deg_o` and `deg_chg_o` are both 0. `deg_chg_o` is high for exactly the one cycle after each edge at which `deg_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Errored-bit count valid |
| err_cnt_i | input | CNT_W | Errored-bit count for one frame |
| tick_i | input | 1 | End-of-interval pulse |
| det_thr_lo_i | input | 16 | Detection threshold, bits 15..0 |
| det_thr_hi_i | input | 4 | Detection threshold, bits 19..16 |
| rec_thr_lo_i | input | 16 | Recovery threshold, bits 15..0 |
| rec_thr_hi_i | input | 4 | Recovery threshold, bits 19..16 |
| det_win_i | input | 4 | Bad intervals needed to declare |
| rec_win_i | input | 4 | Good intervals needed to clear |
| deg_o | output | 1 | Degrade defect level |
| deg_chg_o | output | 1 | One-cycle pulse on a change of `deg_o` |

## Verification
The bench builds the block with CNT_W=16 and ACC_W=20. With these values one interval of twenty full-scale counts goes past the 20-bit ceiling, so the saturation case is reached in a few dozen cycles. A detection threshold of 0xFFFFF then separates a saturating sum from a wrapping one. Small thresholds put the exact equality boundaries within reach, at totals of 99, 100, 10 and 11. Run lengths of 1 and 15 drive both clamp limits.

// File: rtl/deg_pkg.sv
package deg_pkg;
  localparam int WIN_W   = 4;
  localparam int WIN_MIN = 2;
  localparam int WIN_MAX = 10;
  localparam int THR_W   = 20;

  typedef logic [WIN_W-1:0] win_t;

  function automatic win_t win_clamp(input win_t w);
    if (w < win_t'(WIN_MIN))      return win_t'(WIN_MIN);
    else if (w > win_t'(WIN_MAX)) return win_t'(WIN_MAX);
    else                          return w;
  endfunction
endpackage

// File: rtl/deg_accum.sv
module deg_accum #(
  parameter int CNT_W = 16,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_valid_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic             tick_i,
  output logic [ACC_W-1:0] total_o,
  output logic             done_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_ext;
  logic [ACC_W-1:0] add;

  assign add     = err_valid_i ? ACC_W'(err_cnt_i) : '0;
  assign sum_ext = {1'b0, acc_q} + {1'b0, add};
  // saturate rather than wrap
  assign total_o = sum_ext[ACC_W] ? '1 : sum_ext[ACC_W-1:0];
  assign done_o  = tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= '0;
    else             acc_q <= total_o;
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> acc_q >= $past(acc_q));
  // R1
  acc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> acc_q == '0);
endmodule

// File: rtl/deg_state.sv
module deg_state
  import deg_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [ACC_W-1:0] total_i,
  input  logic [THR_W-1:0] det_thr_i,
  input  logic [THR_W-1:0] rec_thr_i,
  input  win_t             det_win_i,
  input  win_t             rec_win_i,
  output logic             deg_o,
  output logic             chg_o
);
  win_t det_win_c, rec_win_c;
  win_t run_q, run_d, run_inc;
  logic deg_q, deg_d, chg_q;
  logic bad, good;

  assign det_win_c = win_clamp(det_win_i);
  assign rec_win_c = win_clamp(rec_win_i);
  assign bad       = total_i >= ACC_W'(det_thr_i);
  assign good      = total_i <= ACC_W'(rec_thr_i);
  assign run_inc   = run_q + win_t'(1);

  // one run counter; its meaning follows the defect level
  always_comb begin
    deg_d = deg_q;
    run_d = run_q;
    if (done_i) begin
      if (!deg_q) begin
        if (!bad)                      run_d = '0;
        else if (run_inc >= det_win_c) begin deg_d = 1'b1; run_d = '0; end
        else                           run_d = run_inc;
      end else begin
        if (!good)                     run_d = '0;
        else if (run_inc >= rec_win_c) begin deg_d = 1'b0; run_d = '0; end
        else                           run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deg_q <= 1'b0;
      run_q <= '0;
      chg_q <= 1'b0;
    end else begin
      deg_q <= deg_d;
      run_q <= run_d;
      chg_q <= deg_d ^ deg_q;
    end
  end

  assign deg_o = deg_q;
  assign chg_o = chg_q;

  // R4
  deg_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(deg_q));
  // R6
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < win_t'(WIN_MAX));
  // R8
  chg_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deg_q != $past(deg_q)) |-> chg_q);
  // R8
  chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> !chg_q);
endmodule

// File: rtl/deg_detector.sv
module deg_detector
  import deg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_valid_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic             tick_i,
  input  logic [15:0]      det_thr_lo_i,
  input  logic [3:0]       det_thr_hi_i,
  input  logic [15:0]      rec_thr_lo_i,
  input  logic [3:0]       rec_thr_hi_i,
  input  logic [3:0]       det_win_i,
  input  logic [3:0]       rec_win_i,
  output logic             deg_o,
  output logic             deg_chg_o
);
  logic [ACC_W-1:0] total;
  logic             done;
  logic [THR_W-1:0] det_thr, rec_thr;

  assign det_thr = {det_thr_hi_i, det_thr_lo_i};
  assign rec_thr = {rec_thr_hi_i, rec_thr_lo_i};

  deg_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_valid_i (err_valid_i),
    .err_cnt_i   (err_cnt_i),
    .tick_i      (tick_i),
    .total_o     (total),
    .done_o      (done)
  );

  deg_state #(.ACC_W(ACC_W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .total_i   (total),
    .det_thr_i (det_thr),
    .rec_thr_i (rec_thr),
    .det_win_i (det_win_i),
    .rec_win_i (rec_win_i),
    .deg_o     (deg_o),
    .chg_o     (deg_chg_o)
  );
endmodule

// File: tb/deg_detector_test.sv
`timescale 1ns/1ps
module deg_detector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [15:0] err_cnt = '0;
  logic        tick = 1'b0;
  logic [15:0] det_lo = '0, rec_lo = '0;
  logic [3:0]  det_hi = '0, rec_hi = '0;
  logic [3:0]  det_win = 4'd3, rec_win = 4'd2;
  logic        deg, chg;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  deg_detector #(.CNT_W(16), .ACC_W(20)) uut (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(err_valid), .err_cnt_i(err_cnt),
    .tick_i(tick), .det_thr_lo_i(det_lo), .det_thr_hi_i(det_hi),
    .rec_thr_lo_i(rec_lo), .rec_thr_hi_i(rec_hi), .det_win_i(det_win),
    .rec_win_i(rec_win), .deg_o(deg), .deg_chg_o(chg));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_thr(input int d, input int r);
    det_lo = d[15:0]; det_hi = d[19:16];
    rec_lo = r[15:0]; rec_hi = r[19:16];
  endtask

  // sum "pre" in chunks, then tick with "on_tick" presented in the tick cycle
  task automatic interval(input int pre, input int on_tick);
    int rem = pre;
    while (rem > 0) begin
      @(negedge clk);
      err_valid = 1'b1;
      err_cnt   = (rem > 65535) ? 16'hFFFF : rem[15:0];
      rem      -= int'(err_cnt);
    end
    @(negedge clk);
    err_valid = (on_tick != 0);
    err_cnt   = on_tick[15:0];
    tick      = 1'b1;
    @(negedge clk);
    tick = 1'b0; err_valid = 1'b0; err_cnt = '0;
  endtask

  task automatic t_reset();
    chk("R8 reset deg", deg, 0);
    chk("R8 reset chg", chg, 0);
  endtask

  task automatic t_detect();
    set_thr(100, 10); det_win = 4'd3; rec_win = 4'd2;
    interval(100, 0); interval(100, 0);
    chk("R4 two of three bad", deg, 0);
    interval(100, 0);
    chk("R2 R4 set at equal thr", deg, 1);
    chk("R8 chg pulse", chg, 1);
    @(negedge clk);
    chk("R8 chg one cycle", chg, 0);
  endtask

  task automatic t_recover();
    interval(10, 0); interval(11, 0); interval(10, 0);
    chk("R5 non-good restarts run", deg, 1);
    interval(200, 0);
    chk("R5 bad while set ignored", deg, 1);
    interval(10, 0); interval(10, 0);
    chk("R3 R5 cleared at equal thr", deg, 0);
    chk("R8 chg on clear", chg, 1);
  endtask

  task automatic t_run_restart();
    interval(100, 0); interval(100, 0); interval(99, 0);
    interval(100, 0); interval(100, 0);
    chk("R2 R4 total 99 restarts run", deg, 0);
    interval(100, 0);
    chk("R4 set after fresh run", deg, 1);
    interval(0, 0); interval(0, 0);
    chk("R5 clear for next test", deg, 0);
  endtask

  task automatic t_same_cycle();
    det_win = 4'd2;
    interval(99, 1); interval(99, 1);
    chk("R1 tick-cycle count included", deg, 1);
    interval(5, 0); interval(5, 0);
    chk("R1 sum restarts after tick", deg, 0);
  endtask

  task automatic t_clamp();
    det_win = 4'd1; rec_win = 4'd15;
    interval(100, 0);
    chk("R6 window 1 acts as 2", deg, 0);
    interval(100, 0);
    chk("R6 set on second bad", deg, 1);
    for (int i = 0; i < 9; i++) interval(0, 0);
    chk("R6 window 15 not cleared at 9", deg, 1);
    interval(0, 0);
    chk("R6 window 15 clears at 10", deg, 0);
  endtask

  task automatic t_saturate();
    set_thr(20'hFFFFF, 10); det_win = 4'd2; rec_win = 4'd2;
    interval(20 * 65535, 0); interval(20 * 65535, 0);
    chk("R7 saturated sum reaches max thr", deg, 1);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_detect();
    t_recover();
    t_run_restart();
    t_same_cycle();
    t_clamp();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule